// File: doc/BRIEF.md
# Timer Unit Register Front End

This block is the bus-facing front end of a timer unit that serves one to eight down-counting channels. It decodes single-word register reads and writes from a simple memory-mapped request port. It owns the shared prescaler that paces every channel, the prescaler reload register, and a read-only capability word. All other accesses are steered into per-channel register windows. The channel counters live in a separate block. This front end gives that block a one-hot select, a register index, write data and a write enable. It returns the selected channel's read word on the bus.

The prescaler counts down once per clock. When it reaches zero it reloads and raises a one-clock tick that goes to all channels, so channels advance once every (reload + 1) clocks. Each channel's interrupt line is registered once and driven out on its own output pin. Read data is registered and stays on the bus until the next read.

Top module: `tmr_unit_front`

## Requirements
- R1: While reset is asserted, `rdata_o`, `tick_o` and `irq_o` are zero. After reset the prescaler value (offset 0x00) and prescaler reload (offset 0x04) both read zero.
- R2: The prescaler value and prescaler reload are 16 bits wide. Write data bits [31:16] are dropped, and reads return the value zero-extended to 32 bits.
- R3: `tick_o` is high for one clock each time the prescaler counter is found at zero and is not being written; the counter then takes the reload value. With reload R and no writes, ticks come every R+1 clocks, and every clock when R is 0.
- R4: A write to offset 0x00 loads the running counter directly and suppresses the tick in that cycle, so the first tick follows V+1 clocks after a write of V. A write to offset 0x04 changes only the reload and leaves the running count alone.
- R5: Offset 0x08 reads the capability word: bits [2:0] the channel count modulo 8, bits [7:3] the base interrupt number, bit 8 set (one interrupt line per channel), bit 9 set (freeze not available), other bits zero. Writes to it are ignored.
- R6: An access whose address bits [7:4] equal c+1 for a channel c below the channel count, with address bits [3:2] not equal to 3, asserts `ch_sel_o[c]` alone in that cycle. It drives `ch_reg_o` = address bits [3:2] (0 counter, 1 reload, 2 configuration), `ch_we_o` = write, and `ch_wdata_o` = the write data.
- R7: A read of a channel register places that channel's `ch_rdata_i` word on `rdata_o` after the clock edge that accepts the read.
- R8: Accesses to offset 0x0C, to offset +0xC of any window, or to a window whose channel index is at or beyond the channel count select no channel and change no register. Reads of these addresses return zero.
- R9: Only address bits [7:0] are decoded; bits [31:8] have no effect.
- R10: `irq_o[c]` equals `ch_irq_i[c]` delayed by one clock.
- R11: `rdata_o` changes only on a clock edge that accepts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one word per accepted cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address; low 8 bits decoded |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| tick_o | output | 1 | Shared prescaler tick to the channels |
| ch_sel_o | output | N_CH | One-hot channel register select |
| ch_we_o | output | 1 | Write strobe to the selected channel |
| ch_reg_o | output | 2 | Register index inside the channel window |
| ch_wdata_o | output | 32 | Write data to the channels |
| ch_rdata_i | input | N_CH*32 | Per-channel read words, channel c in bits [32c+31:32c] |
| ch_irq_i | input | N_CH | Interrupt request from each channel |
| irq_o | output | N_CH | Registered interrupt lines, one per channel |

## Verification
The bench builds the block with three channels and base interrupt number 21. Window indices 4 to 6 then fall beyond the channel count, so out-of-range decoding is reachable. The capability word also carries a non-default count and interrupt field that the bench can compare against 0x3AB. The 16-bit prescaler width is kept, so random reload and load values stay small enough to measure tick spacing cycle by cycle. A stand-in channel register file in the bench answers the select lines, so random channel traffic can be compared with an independent register model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned DEC_W = 8;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PSC_VAL,
    TGT_PSC_RLD,
    TGT_UNIT_CFG,
    TGT_CHAN
  } tgt_e;

  localparam logic [1:0] OFS_A = 2'd0;
  localparam logic [1:0] OFS_B = 2'd1;
  localparam logic [1:0] OFS_C = 2'd2;
  localparam logic [1:0] OFS_X = 2'd3;

  function automatic logic [DW-1:0] unit_cfg(int unsigned n_ch, int unsigned irq_base);
    logic [DW-1:0] w;
    w        = '0;
    w[2:0]   = 3'(n_ch % 8);
    w[7:3]   = 5'(irq_base % 32);
    w[8]     = 1'b1;
    w[9]     = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             val_we_i,
  input  logic             rld_we_i,
  input  logic [PSC_W-1:0] wdata_i,
  output logic [PSC_W-1:0] cnt_o,
  output logic [PSC_W-1:0] rld_o,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q, rld_q;
  logic             tick_q, past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rld_q     <= '0;
      tick_q    <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      tick_q    <= 1'b0;
      if (val_we_i) begin
        cnt_q <= wdata_i;
      end else if (cnt_q == '0) begin
        cnt_q  <= rld_q;
        tick_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (rld_we_i) rld_q <= wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign tick_o = tick_q;

  p_tick_from_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && tick_q) |-> ($past(cnt_q) == '0 && !$past(val_we_i)));
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(val_we_i) && $past(cnt_q) != '0)
      |-> (cnt_q == $past(cnt_q) - 1'b1 && !tick_q));
  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(val_we_i)) |-> (cnt_q == $past(wdata_i) && !tick_q));
  p_reload_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(rld_we_i)) |-> $stable(rld_q));
endmodule

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DEC_W-1:0] addr_i,
  output tgt_e             tgt_o,
  output logic [N_CH-1:0]  ch_hit_o,
  output logic [1:0]       reg_o
);
  logic [3:0] win;
  logic [1:0] ofs;
  logic [N_CH-1:0] hit;

  assign win   = addr_i[7:4];
  assign ofs   = addr_i[3:2];
  assign reg_o = ofs;

  for (genvar g = 0; g < N_CH; g++) begin : g_win
    assign hit[g] = (win == 4'(g + 1)) && (ofs != OFS_X);
  end

  always_comb begin
    tgt_o = TGT_NONE;
    if (win == 4'd0) begin
      case (ofs)
        OFS_A:   tgt_o = TGT_PSC_VAL;
        OFS_B:   tgt_o = TGT_PSC_RLD;
        OFS_C:   tgt_o = TGT_UNIT_CFG;
        default: tgt_o = TGT_NONE;
      endcase
    end else if (|hit) begin
      tgt_o = TGT_CHAN;
    end
  end

  assign ch_hit_o = req_i ? hit : '0;

  p_sel_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_hit_o));
  p_sel_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_hit_o) |-> req_i);
  p_sel_not_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:2] == OFS_X || addr_i[7:4] == 4'd0) |-> (ch_hit_o == '0));
endmodule

// File: rtl/tmr_rdata_mux.sv
module tmr_rdata_mux
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH     = 2,
  parameter int unsigned PSC_W    = 16,
  parameter int unsigned IRQ_BASE = 8
) (
  input  tgt_e               tgt_i,
  input  logic [N_CH-1:0]    ch_hit_i,
  input  logic [PSC_W-1:0]   cnt_i,
  input  logic [PSC_W-1:0]   rld_i,
  input  logic [N_CH*DW-1:0] ch_rdata_i,
  output logic [DW-1:0]      rdata_o
);
  localparam logic [DW-1:0] CFG_WORD = unit_cfg(N_CH, IRQ_BASE);

  logic [DW-1:0] ch_word;

  always_comb begin
    ch_word = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (ch_hit_i[c]) ch_word = ch_word | ch_rdata_i[c*DW +: DW];
    end
  end

  always_comb begin
    case (tgt_i)
      TGT_PSC_VAL:  rdata_o = DW'(cnt_i);
      TGT_PSC_RLD:  rdata_o = DW'(rld_i);
      TGT_UNIT_CFG: rdata_o = CFG_WORD;
      TGT_CHAN:     rdata_o = ch_word;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_unit_front.sv
module tmr_unit_front
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH     = 2,
  parameter int unsigned IRQ_BASE = 8,
  parameter int unsigned PSC_W    = 16,
  parameter int unsigned AW       = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               tick_o,
  output logic [N_CH-1:0]    ch_sel_o,
  output logic               ch_we_o,
  output logic [1:0]         ch_reg_o,
  output logic [DW-1:0]      ch_wdata_o,
  input  logic [N_CH*DW-1:0] ch_rdata_i,
  input  logic [N_CH-1:0]    ch_irq_i,
  output logic [N_CH-1:0]    irq_o
);
  if (N_CH < 1 || N_CH > 8) begin : g_bad_cfg
    $error("channel count out of range");
  end

  tgt_e            tgt;
  logic [N_CH-1:0] ch_hit;
  logic [1:0]      reg_idx;
  logic            wr, rd;
  logic [DW-1:0]   rd_word, rdata_q;
  logic [N_CH-1:0] irq_q;
  logic [PSC_W-1:0] psc_cnt, psc_rld;
  logic            past_ok_q;

  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  tmr_addr_decode #(.N_CH(N_CH)) i_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .addr_i   (addr_i[DEC_W-1:0]),
    .tgt_o    (tgt),
    .ch_hit_o (ch_hit),
    .reg_o    (reg_idx)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .val_we_i (wr && tgt == TGT_PSC_VAL),
    .rld_we_i (wr && tgt == TGT_PSC_RLD),
    .wdata_i  (wdata_i[PSC_W-1:0]),
    .cnt_o    (psc_cnt),
    .rld_o    (psc_rld),
    .tick_o   (tick_o)
  );

  tmr_rdata_mux #(.N_CH(N_CH), .PSC_W(PSC_W), .IRQ_BASE(IRQ_BASE)) i_mux (
    .tgt_i      (tgt),
    .ch_hit_i   (ch_hit),
    .cnt_i      (psc_cnt),
    .rld_i      (psc_rld),
    .ch_rdata_i (ch_rdata_i),
    .rdata_o    (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      irq_q     <= '0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      irq_q     <= ch_irq_i;
      if (rd) rdata_q <= rd_word;
    end
  end

  assign rdata_o    = rdata_q;
  assign irq_o      = irq_q;
  assign ch_sel_o   = ch_hit;
  assign ch_we_o    = wr && (tgt == TGT_CHAN);
  assign ch_reg_o   = reg_idx;
  assign ch_wdata_o = wdata_i;

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(rd) && $past(tgt) == TGT_NONE) |-> (rdata_o == '0));
  p_irq_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (irq_o == $past(ch_irq_i)));
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(rd)) |-> $stable(rdata_o));
  p_chan_we_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_we_o |-> ($onehot(ch_sel_o) && we_i));
endmodule

// File: tb/test_tmr_unit_front.sv
`timescale 1ns/1ps
module test_tmr_unit_front;
  localparam int N  = 3;
  localparam int IB = 21;
  localparam logic [31:0] CFG_EXP = 32'h0000_03AB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic tick, ch_we;
  logic [N-1:0] ch_sel, irq_in = '0, irq_out;
  logic [1:0] ch_reg;
  logic [31:0] ch_wdata;
  logic [N*32-1:0] ch_rdata;
  logic [31:0] fmem [N][4];
  logic [31:0] exp_mem [N][4];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_unit_front #(.N_CH(N), .IRQ_BASE(IB)) i_tmr_unit_front (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick), .ch_sel_o(ch_sel),
    .ch_we_o(ch_we), .ch_reg_o(ch_reg), .ch_wdata_o(ch_wdata),
    .ch_rdata_i(ch_rdata), .ch_irq_i(irq_in), .irq_o(irq_out)
  );

  // stand-in channel registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) for (int j = 0; j < 4; j++) fmem[i][j] <= '0;
    end else begin
      for (int i = 0; i < N; i++) if (ch_sel[i] && ch_we) fmem[i][ch_reg] <= ch_wdata;
    end
  end
  always_comb for (int i = 0; i < N; i++) ch_rdata[i*32 +: 32] = fmem[i][ch_reg];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int chan_of(input logic [31:0] a);
    int w, o;
    w = int'(a[7:4]);
    o = int'(a[3:2]);
    if (w >= 1 && w <= N && o != 3) return w - 1;
    return -1;
  endfunction

  // entered just after a negedge, returns just after the next one
  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    int c;
    logic [N-1:0] exp_sel;
    req = 1'b1; we = w; addr = a; wdata = d;
    c = chan_of(a);
    exp_sel = (c >= 0) ? N'(1 << c) : '0;
    #1;
    chk(c >= 0 ? "R6 select" : "R8 no select", 32'(ch_sel), 32'(exp_sel));
    if (c >= 0) begin
      chk("R6 reg index", 32'(ch_reg), 32'(a[3:2]));
      chk("R6 write strobe", 32'(ch_we), 32'(w));
      if (w) chk("R6 write data", ch_wdata, d);
    end
    @(negedge clk);
    r = rdata;
    req = 1'b0; we = 1'b0;
    if (w && c >= 0) exp_mem[c][a[3:2]] = d;
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r;
    access(1'b1, a, d, r);
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] r);
    access(1'b0, a, 32'h0, r);
  endtask

  task automatic tick_trial(input int rv, input int vv);
    int n, m;
    bus_wr(32'h04, 32'(rv));
    bus_wr(32'h00, 32'(vv));
    chk("R4 no tick on load", 32'(tick), 32'h0);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
    chk("R4 first tick after load", 32'(n), 32'(vv + 1));
    for (int k = 0; k < 2; k++) begin
      m = 0;
      do begin @(negedge clk); m++; end while (!tick && m < 100);
      chk("R3 tick spacing", 32'(m), 32'(rv + 1));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, last;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) for (int j = 0; j < 4; j++) exp_mem[i][j] = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 tick in reset", 32'(tick), 32'h0);
    chk("R1 irq in reset", 32'(irq_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    bus_rd(32'h00, r); chk("R1 prescaler value after reset", r, 32'h0);
    bus_rd(32'h04, r); chk("R1 prescaler reload after reset", r, 32'h0);

    // R2: upper bits dropped
    bus_wr(32'h04, 32'hDEAD_0007);
    bus_rd(32'h04, r); chk("R2 reload width", r, 32'h0000_0007);
    bus_wr(32'h00, 32'hBEEF_0123);
    bus_rd(32'h00, r); chk("R2 value width", r, 32'h0000_0123);
    bus_rd(32'h00, r); chk("R2 value counts down", r, 32'h0000_0122);

    // R3/R4: directed then random tick timing
    tick_trial(0, 0);
    tick_trial(0, 4);
    tick_trial(5, 0);
    for (int t = 0; t < 6; t++) tick_trial(int'($urandom % 13), int'($urandom % 13));

    // R4: reload write leaves running count
    bus_wr(32'h04, 32'd3);
    bus_wr(32'h00, 32'd10);
    bus_wr(32'h04, 32'd7);
    n = 1;
    while (!tick && n < 100) begin @(negedge clk); n++; end
    chk("R4 reload write keeps count", 32'(n), 32'd11);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
    chk("R4 new reload used after wrap", 32'(n), 32'd8);

    // R5
    bus_rd(32'h08, r); chk("R5 capability word", r, CFG_EXP);
    bus_wr(32'h08, 32'hFFFF_FFFF);
    bus_rd(32'h08, r); chk("R5 capability after write", r, CFG_EXP);
    bus_rd(32'h04, r); chk("R5 write ignored, reload kept", r, 32'd7);

    // R9
    bus_rd(32'hABCD_EF04, r); chk("R9 upper address ignored on read", r, 32'd7);
    bus_wr(32'h1234_5614, 32'hCAFE_0001);
    bus_rd(32'h0000_0014, r); chk("R9 upper address ignored on write", r, 32'hCAFE_0001);

    // R8
    bus_rd(32'h08, r);
    bus_rd(32'h0C, r); chk("R8 unit hole reads zero", r, 32'h0);
    bus_rd(32'h14, r);
    bus_rd(32'h1C, r); chk("R8 window hole reads zero", r, 32'h0);
    bus_rd(32'h14, r);
    bus_rd(32'h44, r); chk("R8 channel beyond count reads zero", r, 32'h0);
    bus_wr(32'h44, 32'hFFFF_FFFF);
    bus_wr(32'h1C, 32'hFFFF_FFFF);
    bus_wr(32'h0C, 32'hFFFF_FFFF);
    for (int c = 0; c < N; c++)
      for (int o = 0; o < 3; o++) begin
        bus_rd(32'((c + 1) * 16 + o * 4), r);
        chk("R8 no stray write", r, exp_mem[c][o]);
      end
    bus_rd(32'h04, r); chk("R8 prescaler untouched", r, 32'd7);

    // R6/R7/R8: random channel traffic
    for (int it = 0; it < 300; it++) begin
      logic [31:0] a, d;
      int c;
      a = {$urandom % 32'h0100_0000, 4'(1 + $urandom % 6), 2'($urandom % 4), 2'b00};
      d = $urandom;
      c = chan_of(a);
      if ($urandom % 2) bus_wr(a, d);
      else begin
        bus_rd(a, r);
        chk(c >= 0 ? "R7 channel read" : "R8 unmapped read", r,
            c >= 0 ? exp_mem[c][a[3:2]] : 32'h0);
      end
    end

    // R10
    for (int it = 0; it < 20; it++) begin
      logic [N-1:0] p;
      p = N'($urandom);
      irq_in = p;
      @(negedge clk);
      chk("R10 irq delay", 32'(irq_out), 32'(p));
    end

    // R11
    bus_rd(32'h08, last);
    bus_wr(32'h24, 32'h5555_AAAA);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", rdata, last);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule